// File: doc/BRIEF.md
# Interrupt Pending Enable Register Bank

This block holds per-line state for a set of external interrupt request lines: an enable bit, a pending bit, an active bit and a priority field for each line. Software reaches the state through a 32-bit register bus. The bus has an address, a write strobe, write data and read data. Enable and pending state each have two addresses: one where written ones set bits and one where written ones clear them. A write-only trigger address pends a single line by its number. Hardware can also raise pending state on a rising request line. A core reports handler entry and exit through two strobes, and these move a line from pending to active and back to idle.

The bus accepts one access every cycle and never stalls, so there is no back-pressure on it. Read data is combinational from the address and shows register state as of the last clock edge. The block continuously presents the pending, enabled line that has the lowest priority value. Ties go to the lower line number. A valid flag qualifies that output. Request lines are taken as low while reset is asserted, so a line that is high when reset is released counts as a rising edge.

Byte address map, with word index n covering lines 32n to 32n+31 and bit k standing for line 32n+k:

| Offset | Access |
|---|---|
| 0x000 + 4n | enable, ones set |
| 0x080 + 4n | enable, ones clear |
| 0x100 + 4n | pending, ones set |
| 0x180 + 4n | pending, ones clear |
| 0x200 + 4n | active, read-only |
| 0x300 + 4m | priority: byte j is line 4m+j |
| 0x400 | trigger: write-only, line number in bits 8:0 |

Top module: `irq_bank`

## Requirements
- R1: After reset, every enable, pending, active and priority bit reads 0, and top_vld is low.
- R2: A write to enable word n at offset 0x000+4n sets enable of line 32n+k for each data bit k that is 1. Bits written as 0 are left alone. A write at offset 0x080+4n clears enable for each bit written as 1. Both offsets read back the current enable word.
- R3: Pending state follows the same rules as enable, with its set words at 0x100+4n and its clear words at 0x180+4n. Both offsets read back the current pending word.
- R4: A write to offset 0x400 pends the line whose number is in data bits 8:0. Number 0 pends line 0. A number at or above NUM_IRQ changes nothing. Data bits 31:9 are ignored. Reads of 0x400 return 0.
- R5: enter_vld with enter_num below NUM_IRQ sets that line's active bit and clears its pending bit at the same clock edge. exit_vld clears the active bit of exit_num. If both strobes name the same line in one cycle, the line stays active. Active words at 0x200+4n are read-only, and writes to them have no effect.
- R6: Each line has a PRIO_W-bit priority. Line 4m+j is held in bits 8j+PRIO_W-1 down to 8j of the word at 0x300+4m. A write sets all four fields of that word, and a read returns them.
- R7: A 0-to-1 transition of irq_lines[i] between two clock edges sets pending bit i whether or not the line is enabled. A line that stays high does not set pending again after the bit has been cleared.
- R8: top_vld is high exactly when some line is both pending and enabled. top_num is the qualifying line with the numerically lowest priority, with ties going to the lower line number, and top_prio is that line's priority.
- R9: When a set source and a clear source reach the same pending bit in one cycle, the clear wins. Set sources are a request edge, a set write and a trigger. Clear sources are a clear write and entry.
- R10: Reads of unmapped offsets, and of word indices beyond the configured lines, return 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_lines | input | NUM_IRQ | Interrupt request levels |
| enter_vld | input | 1 | Handler entry strobe |
| enter_num | input | 9 | Line number being entered |
| exit_vld | input | 1 | Handler exit strobe |
| exit_num | input | 9 | Line number being left |
| top_vld | output | 1 | Some line is pending and enabled |
| top_num | output | 9 | Line number of the selected line |
| top_prio | output | PRIO_W | Priority of the selected line |

## Verification
The hardest situation to reach is a set and a clear landing on the same pending bit in the same cycle. Only one bus write can happen per cycle, so the bench makes the collision with a second source. It raises a request line in the same cycle as a pending-clear write for that bit. It also issues a trigger write in the same cycle as an entry strobe for the same line. The selection output is checked against a linear scan computed in the bench. The bench sweeps many pending and enable patterns under spread-out priorities, equal priorities, and priorities that repeat every three lines, so that ties are exercised.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int WORD_W      = 32;
  localparam int NUM_FIELD_W = 9;
  localparam int BLK_SHIFT   = 7;
  localparam int IDX_W       = 6;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_ENA_SET,
    RG_ENA_CLR,
    RG_PND_SET,
    RG_PND_CLR,
    RG_ACT,
    RG_PRIO,
    RG_TRIG
  } irq_region_e;
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output irq_region_e       region,
  output logic [IDX_W-1:0]  word_idx
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  logic [BLK_W-1:0] blk;
  logic             unused_lanes;

  assign blk          = addr[ADDR_W-1:BLK_SHIFT];
  assign unused_lanes = ^addr[1:0];

  always_comb begin
    region   = RG_NONE;
    word_idx = {1'b0, addr[6:2]};
    case (blk)
      BLK_W'(0): region = RG_ENA_SET;
      BLK_W'(1): region = RG_ENA_CLR;
      BLK_W'(2): region = RG_PND_SET;
      BLK_W'(3): region = RG_PND_CLR;
      BLK_W'(4): region = RG_ACT;
      BLK_W'(6), BLK_W'(7): begin
        region   = RG_PRIO;
        word_idx = {blk[0], addr[6:2]};
      end
      BLK_W'(8): if (addr[6:2] == 5'd0) region = RG_TRIG;
      default:   region = RG_NONE;
    endcase
  end
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  irq_region_e            region,
  input  logic [IDX_W-1:0]       word_idx,
  input  logic [WORD_W-1:0]      wdata,
  input  logic [NUM_IRQ-1:0]     irq_lines,
  input  logic                   enter_vld,
  input  logic [NUM_FIELD_W-1:0] enter_num,
  input  logic                   exit_vld,
  input  logic [NUM_FIELD_W-1:0] exit_num,
  output logic [NUM_IRQ-1:0]     ena_q,
  output logic [NUM_IRQ-1:0]     pend_q,
  output logic [NUM_IRQ-1:0]     act_q,
  output logic [WORD_W-1:0]      rd_word
);
  localparam int NW  = (NUM_IRQ + WORD_W - 1) / WORD_W;
  localparam int PAD = NW * WORD_W;

  logic                   trig_hit;
  logic [NUM_FIELD_W-1:0] trig_num;

  assign trig_hit = wr && (region == RG_TRIG);
  assign trig_num = wdata[NUM_FIELD_W-1:0];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    localparam int W = i / WORD_W;
    localparam int K = i % WORD_W;
    logic hit_w, s_e, c_e, s_p, c_p, s_a, c_a;
    logic e_r, p_r, a_r, l_r;

    assign hit_w = wr && (word_idx == IDX_W'(W));
    assign s_e   = hit_w && (region == RG_ENA_SET) && wdata[K];
    assign c_e   = hit_w && (region == RG_ENA_CLR) && wdata[K];
    assign s_a   = enter_vld && (enter_num == NUM_FIELD_W'(i));
    assign c_a   = exit_vld && (exit_num == NUM_FIELD_W'(i));
    assign s_p   = (hit_w && (region == RG_PND_SET) && wdata[K])
                || (irq_lines[i] && !l_r)
                || (trig_hit && (trig_num == NUM_FIELD_W'(i)));
    assign c_p   = (hit_w && (region == RG_PND_CLR) && wdata[K]) || s_a;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_r <= 1'b0;
        p_r <= 1'b0;
        a_r <= 1'b0;
        l_r <= 1'b0;
      end else begin
        e_r <= (e_r | s_e) & ~c_e;
        p_r <= (p_r | s_p) & ~c_p;
        a_r <= (a_r & ~c_a) | s_a;
        l_r <= irq_lines[i];
      end
    end

    assign ena_q[i]  = e_r;
    assign pend_q[i] = p_r;
    assign act_q[i]  = a_r;
  end

  logic [PAD-1:0] ena_pad, pend_pad, act_pad;

  always_comb begin
    ena_pad  = '0;
    pend_pad = '0;
    act_pad  = '0;
    ena_pad[NUM_IRQ-1:0]  = ena_q;
    pend_pad[NUM_IRQ-1:0] = pend_q;
    act_pad[NUM_IRQ-1:0]  = act_q;
  end

  always_comb begin
    rd_word = '0;
    if (int'(word_idx) < NW) begin
      case (region)
        RG_ENA_SET, RG_ENA_CLR: rd_word = ena_pad[WORD_W*int'(word_idx) +: WORD_W];
        RG_PND_SET, RG_PND_CLR: rd_word = pend_pad[WORD_W*int'(word_idx) +: WORD_W];
        RG_ACT:                 rd_word = act_pad[WORD_W*int'(word_idx) +: WORD_W];
        default:                rd_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  irq_region_e               region,
  input  logic [IDX_W-1:0]          word_idx,
  input  logic [WORD_W-1:0]         wdata,
  output logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic [WORD_W-1:0]         rd_word
);
  localparam int PER_WORD = WORD_W / 8;

  logic wr_hit;
  assign wr_hit = wr && (region == RG_PRIO);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_field
    localparam int W = i / PER_WORD;
    localparam int B = i % PER_WORD;
    logic [PRIO_W-1:0] p_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        p_r <= '0;
      else if (wr_hit && (word_idx == IDX_W'(W)))
        p_r <= wdata[8*B +: PRIO_W];
    end

    assign prio_flat[i*PRIO_W +: PRIO_W] = p_r;
  end

  always_comb begin
    rd_word = '0;
    if (region == RG_PRIO) begin
      for (int b = 0; b < PER_WORD; b++) begin
        if (PER_WORD*int'(word_idx) + b < NUM_IRQ)
          rd_word[8*b +: PRIO_W] = prio_flat[(PER_WORD*int'(word_idx) + b)*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_pick_tree.sv
module irq_pick_tree
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_IRQ-1:0]        req,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic                      win_vld,
  output logic [NUM_FIELD_W-1:0]    win_num,
  output logic [PRIO_W-1:0]         win_prio
);
  localparam int LVL    = $clog2(NUM_IRQ);
  localparam int LEAVES = 1 << LVL;

  for (genvar g = 0; g <= LVL; g++) begin : g_lvl
    localparam int CNT = LEAVES >> g;
    logic [CNT-1:0]             v;
    logic [CNT*PRIO_W-1:0]      p;
    logic [CNT*NUM_FIELD_W-1:0] n;

    if (g == 0) begin : g_leaf
      for (genvar l = 0; l < CNT; l++) begin : g_l
        if (l < NUM_IRQ) begin : g_real
          assign v[l] = req[l];
          assign p[l*PRIO_W +: PRIO_W] = prio_flat[l*PRIO_W +: PRIO_W];
          assign n[l*NUM_FIELD_W +: NUM_FIELD_W] = NUM_FIELD_W'(l);
        end else begin : g_pad
          assign v[l] = 1'b0;
          assign p[l*PRIO_W +: PRIO_W] = '0;
          assign n[l*NUM_FIELD_W +: NUM_FIELD_W] = '0;
        end
      end
    end else begin : g_node
      for (genvar j = 0; j < CNT; j++) begin : g_j
        logic                   lv, rv, take_l;
        logic [PRIO_W-1:0]      lp, rp;
        logic [NUM_FIELD_W-1:0] ln, rn;

        assign lv = g_lvl[g-1].v[2*j];
        assign rv = g_lvl[g-1].v[2*j+1];
        assign lp = g_lvl[g-1].p[(2*j)*PRIO_W +: PRIO_W];
        assign rp = g_lvl[g-1].p[(2*j+1)*PRIO_W +: PRIO_W];
        assign ln = g_lvl[g-1].n[(2*j)*NUM_FIELD_W +: NUM_FIELD_W];
        assign rn = g_lvl[g-1].n[(2*j+1)*NUM_FIELD_W +: NUM_FIELD_W];
        // left child always carries the lower line numbers, so <= gives ties to it
        assign take_l = lv && (!rv || (lp <= rp));

        assign v[j] = lv | rv;
        assign p[j*PRIO_W +: PRIO_W] = take_l ? lp : rp;
        assign n[j*NUM_FIELD_W +: NUM_FIELD_W] = take_l ? ln : rn;
      end
    end
  end

  assign win_vld  = g_lvl[LVL].v[0];
  assign win_prio = g_lvl[LVL].p[PRIO_W-1:0];
  assign win_num  = g_lvl[LVL].n[NUM_FIELD_W-1:0];
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int PRIO_W  = 8,
  parameter int ADDR_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  input  logic [NUM_IRQ-1:0]     irq_lines,
  input  logic                   enter_vld,
  input  logic [NUM_FIELD_W-1:0] enter_num,
  input  logic                   exit_vld,
  input  logic [NUM_FIELD_W-1:0] exit_num,
  output logic                   top_vld,
  output logic [NUM_FIELD_W-1:0] top_num,
  output logic [PRIO_W-1:0]      top_prio
);
  irq_region_e               region;
  logic [IDX_W-1:0]          word_idx;
  logic [NUM_IRQ-1:0]        ena_q, pend_q, act_q;
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic [WORD_W-1:0]         st_rd, pr_rd;

  irq_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr     (bus_addr),
    .region   (region),
    .word_idx (word_idx)
  );

  irq_state_bank #(.NUM_IRQ(NUM_IRQ)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .region    (region),
    .word_idx  (word_idx),
    .wdata     (bus_wdata),
    .irq_lines (irq_lines),
    .enter_vld (enter_vld),
    .enter_num (enter_num),
    .exit_vld  (exit_vld),
    .exit_num  (exit_num),
    .ena_q     (ena_q),
    .pend_q    (pend_q),
    .act_q     (act_q),
    .rd_word   (st_rd)
  );

  irq_prio_store #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .region    (region),
    .word_idx  (word_idx),
    .wdata     (bus_wdata),
    .prio_flat (prio_flat),
    .rd_word   (pr_rd)
  );

  irq_pick_tree #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_pick (
    .req       (ena_q & pend_q),
    .prio_flat (prio_flat),
    .win_vld   (top_vld),
    .win_num   (top_num),
    .win_prio  (top_prio)
  );

  // each source returns zero outside its own region
  assign bus_rdata = st_rd | pr_rd;
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int PRIO_W  = 8,
  parameter int ADDR_W  = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_wr,
  input logic [WORD_W-1:0]         bus_wdata,
  input logic                      enter_vld,
  input logic [NUM_FIELD_W-1:0]    enter_num,
  input logic                      exit_vld,
  input logic                      top_vld,
  input logic [NUM_FIELD_W-1:0]    top_num,
  input logic [PRIO_W-1:0]         top_prio,
  input logic [NUM_IRQ-1:0]        ena_q,
  input logic [NUM_IRQ-1:0]        pend_q,
  input logic [NUM_IRQ-1:0]        act_q,
  input logic [NUM_IRQ*PRIO_W-1:0] prio_flat
);
  localparam logic [NUM_FIELD_W-1:0] LIM = NUM_FIELD_W'(NUM_IRQ);

  logic [NUM_IRQ-1:0] clr_mask;
  logic               unused_chk;
  assign unused_chk = ^bus_addr[1:0];

  always_comb begin
    clr_mask = '0;
    if (bus_wr && (bus_addr[ADDR_W-1:7] == (ADDR_W-7)'(1))) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (((i / 32) == int'(bus_addr[6:2])) && bus_wdata[i % 32]) clr_mask[i] = 1'b1;
    end
  end

  p_ena_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((ena_q & $past(clr_mask)) == '0));

  // entry also wins over any same-cycle pending set (R9)
  p_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_vld && (enter_num < LIM)) |=> (act_q[$past(enter_num)] && !pend_q[$past(enter_num)]));

  p_act_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter_vld && !exit_vld) |=> $stable(act_q));

  p_top_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
    top_vld |-> ((top_num < LIM) && ena_q[top_num] && pend_q[top_num]));

  p_none_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ena_q & pend_q) == '0) |-> !top_vld);

  p_top_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    top_vld |-> (top_prio == prio_flat[top_num*PRIO_W +: PRIO_W]));
endmodule

bind irq_bank irq_bank_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .enter_vld (enter_vld),
  .enter_num (enter_num),
  .exit_vld  (exit_vld),
  .top_vld   (top_vld),
  .top_num   (top_num),
  .top_prio  (top_prio),
  .ena_q     (ena_q),
  .pend_q    (pend_q),
  .act_q     (act_q),
  .prio_flat (prio_flat)
);

// File: tb/irq_bank_bench.sv
module irq_bank_bench;
  localparam int N   = 40;
  localparam int PW  = 8;
  localparam int AW  = 12;
  localparam int NW  = 2;
  localparam int NPW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_lines = '0;
  logic          enter_vld = 1'b0;
  logic [8:0]    enter_num = '0;
  logic          exit_vld = 1'b0;
  logic [8:0]    exit_num = '0;
  logic          top_vld;
  logic [8:0]    top_num;
  logic [PW-1:0] top_prio;

  always #5 clk = ~clk;

  irq_bank #(.NUM_IRQ(N), .PRIO_W(PW), .ADDR_W(AW)) u_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .enter_vld(enter_vld), .enter_num(enter_num), .exit_vld(exit_vld),
    .exit_num(exit_num), .top_vld(top_vld), .top_num(top_num), .top_prio(top_prio)
  );

  logic [N-1:0] m_ena = '0, m_pend = '0, m_act = '0, m_line = '0;
  logic [7:0]   m_prio [N];
  logic [N-1:0] cur_lines = '0;
  int n_chk = 0;
  int n_err = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wsel(logic [N-1:0] v, int w);
    logic [63:0] pad;
    pad = '0;
    pad[N-1:0] = v;
    return pad[32*w +: 32];
  endfunction

  task automatic cyc(bit wr, logic [11:0] a, logic [31:0] d, logic [N-1:0] lines,
                     bit ev, int en, bit xv, int xn);
    logic [N-1:0] se, ce, sp, cp, sa, ca;
    logic [127:0] tmp;
    int blk, idx;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; irq_lines = lines;
    enter_vld = ev; enter_num = 9'(en); exit_vld = xv; exit_num = 9'(xn);
    @(posedge clk);
    se = '0; ce = '0; cp = '0; sa = '0; ca = '0;
    sp = lines & ~m_line;
    tmp = {96'b0, d} << (32 * int'(a[6:2]));
    blk = int'(a[11:7]);
    idx = int'(a[6:2]);
    if (wr) begin
      case (blk)
        0: se = tmp[N-1:0];
        1: ce = tmp[N-1:0];
        2: sp = sp | tmp[N-1:0];
        3: cp = tmp[N-1:0];
        6, 7: for (int j = 0; j < 4; j++)
                if (((blk - 6) * 32 + idx) * 4 + j < N)
                  m_prio[((blk - 6) * 32 + idx) * 4 + j] = d[8*j +: 8];
        8: if (idx == 0 && int'(d[8:0]) < N) sp[int'(d[8:0])] = 1'b1;
        default: ;
      endcase
    end
    if (ev && en < N) begin cp[en] = 1'b1; sa[en] = 1'b1; end
    if (xv && xn < N) ca[xn] = 1'b1;
    m_ena  = (m_ena | se) & ~ce;
    m_pend = (m_pend | sp) & ~cp;
    m_act  = (m_act & ~ca) | sa;
    m_line = lines;
    #1;
    bus_wr = 1'b0; enter_vld = 1'b0; exit_vld = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    cyc(1'b1, a, d, cur_lines, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic check_all(string tag);
    int best;
    logic [31:0] exp, act;
    @(negedge clk);
    for (int w = 0; w < NW; w++) begin
      rd_chk({tag, " ena-set"}, 12'(w*4), wsel(m_ena, w));
      rd_chk({tag, " ena-clr"}, 12'('h80 + w*4), wsel(m_ena, w));
      rd_chk({tag, " pnd-set"}, 12'('h100 + w*4), wsel(m_pend, w));
      rd_chk({tag, " pnd-clr"}, 12'('h180 + w*4), wsel(m_pend, w));
      rd_chk({tag, " active"}, 12'('h200 + w*4), wsel(m_act, w));
    end
    for (int w = 0; w < NPW; w++) begin
      exp = '0;
      for (int j = 0; j < 4; j++) if (w*4 + j < N) exp[8*j +: 8] = m_prio[w*4 + j];
      rd_chk({tag, " prio"}, 12'('h300 + w*4), exp);
    end
    best = -1;
    for (int i = 0; i < N; i++)
      if (m_ena[i] && m_pend[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
    exp = (best < 0) ? 32'd0 : {14'd0, 1'b1, 9'(best), m_prio[best]};
    act = top_vld ? {14'd0, 1'b1, top_num, top_prio} : 32'd0;
    chk({tag, " top R8"}, act, exp);
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_prio[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_all("R1");

    // R2 enable set/clear, one line at a time then patterns
    for (int i = 0; i < N; i++) begin
      wr(12'(4*(i/32)), 32'(1) << (i % 32));
      if (i % 5 == 0) check_all("R2");
    end
    wr(12'h000, 32'h0); check_all("R2 zero-set");
    wr(12'h080, 32'h5A5A5A5A); check_all("R2 clr");
    wr(12'h084, 32'hFFFFFFFF); check_all("R2 clr");
    wr(12'h080, 32'h0); check_all("R2 zero-clr");
    wr(12'h004, 32'h000000C3); check_all("R2 set");

    // R10 out-of-range words and unmapped offsets
    wr(12'h008, 32'hFFFFFFFF); check_all("R10 word2");
    wr(12'h500, 32'hFFFFFFFF); check_all("R10 unmapped");
    @(negedge clk);
    rd_chk("R10 read word2", 12'h008, 32'h0);
    rd_chk("R10 read 0x500", 12'h500, 32'h0);
    rd_chk("R10 read prio beyond", 12'(32'h300 + 4*NPW), 32'h0);

    // R6 priorities
    for (int w = 0; w < NPW; w++) begin
      logic [31:0] d;
      for (int j = 0; j < 4; j++) d[8*j +: 8] = 8'((w*4 + j) * 37 + 11);
      wr(12'('h300 + 4*w), d);
    end
    check_all("R6");

    // R4 trigger sweep over every number, past the end, and extremes
    for (int n = 0; n < N + 4; n++) begin
      wr(12'h400, 32'hABCDE000 | 32'(n));
      check_all("R4");
      @(negedge clk);
      rd_chk("R4 read trigger", 12'h400, 32'h0);
      wr(12'h180, 32'hFFFFFFFF); wr(12'h184, 32'hFFFFFFFF);
    end
    wr(12'h400, 32'h1FF); check_all("R4 511");

    // R3 pending aliases
    wr(12'h100, 32'h12345678); wr(12'h104, 32'hFF); check_all("R3 set");
    wr(12'h180, 32'h0F0F0F0F); check_all("R3 clr");
    wr(12'h100, 32'h0); wr(12'h184, 32'h0); check_all("R3 zero");

    // R8 selection sweeps with three priority layouts
    for (int layout = 0; layout < 3; layout++) begin
      for (int w = 0; w < NPW; w++) begin
        logic [31:0] d;
        for (int j = 0; j < 4; j++)
          d[8*j +: 8] = (layout == 0) ? 8'((w*4 + j) * 101 + 7)
                      : (layout == 1) ? 8'd5 : 8'((w*4 + j) % 3);
        wr(12'('h300 + 4*w), d);
      end
      for (int p = 0; p < 48; p++) begin
        wr(12'h000, 32'hFFFFFFFF); wr(12'h004, 32'hFF);
        wr(12'h080, 32'(p) * 32'h11111111);
        wr(12'h180, 32'hFFFFFFFF); wr(12'h184, 32'hFFFFFFFF);
        wr(12'h100, 32'(p + 1) * 32'h9E3779B9);
        wr(12'h104, 32'((p * 7) & 255));
        check_all("R8");
      end
    end

    // R7 request edges, including disabled lines
    wr(12'h080, 32'hFFFFFFFF); wr(12'h084, 32'hFFFFFFFF);
    wr(12'h180, 32'hFFFFFFFF); wr(12'h184, 32'hFFFFFFFF);
    cur_lines = 40'h80_0000_1005;
    cyc(1'b0, 12'h0, 32'h0, cur_lines, 1'b0, 0, 1'b0, 0);
    check_all("R7 rise");
    wr(12'h180, 32'hFFFFFFFF); wr(12'h184, 32'hFFFFFFFF);
    cyc(1'b0, 12'h0, 32'h0, cur_lines, 1'b0, 0, 1'b0, 0);
    check_all("R7 held");
    cur_lines = '0;
    cyc(1'b0, 12'h0, 32'h0, cur_lines, 1'b0, 0, 1'b0, 0);
    cur_lines = 40'h00_0000_0005;
    cyc(1'b0, 12'h0, 32'h0, cur_lines, 1'b0, 0, 1'b0, 0);
    check_all("R7 re-rise");

    // R9 collisions: edge against clear write, trigger against entry
    cur_lines = '0;
    wr(12'h180, 32'hFFFFFFFF);
    cur_lines = 40'h8;
    cyc(1'b1, 12'h180, 32'h8, cur_lines, 1'b0, 0, 1'b0, 0);
    check_all("R9 edge-vs-clear");
    cyc(1'b1, 12'h400, 32'd9, cur_lines, 1'b1, 9, 1'b0, 0);
    check_all("R9 trigger-vs-entry");

    // R5 entry and exit
    for (int k = 0; k < 6; k++) begin
      int ln;
      ln = (k * 13 + 2) % N;
      wr(12'h400, 32'(ln));
      cyc(1'b0, 12'h0, 32'h0, cur_lines, 1'b1, ln, 1'b0, 0);
      check_all("R5 entry");
      wr(12'h200, 32'h0);
      wr(12'h204, 32'hFFFFFFFF);
      check_all("R5 ro-active");
    end
    cyc(1'b0, 12'h0, 32'h0, cur_lines, 1'b1, 15, 1'b1, 15);
    check_all("R5 enter+exit");
    cyc(1'b0, 12'h0, 32'h0, cur_lines, 1'b0, 0, 1'b1, 2);
    cyc(1'b0, 12'h0, 32'h0, cur_lines, 1'b0, 0, 1'b1, 15);
    check_all("R5 exit");
    cyc(1'b0, 12'h0, 32'h0, cur_lines, 1'b1, 300, 1'b0, 0);
    check_all("R5 out-of-range");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule